// File: doc/BRIEF.md
# MCU Reset Sequencer with Sticky Status Flags

This block decides when the core of a small microcontroller is held in reset and why. It watches four reset sources: an asynchronous power-on input, an external active-low reset pin, a low-voltage detector output and a watchdog expiry strobe. For each event it holds an internal reset for a timed interval. The interval depends on the source and on the oscillator configuration. The block also keeps two sticky status flags that software reads after reset. One flag records that the watchdog expired. The other records that the part went through power-down (sleep).

Two kinds of reset leave the block. A full reset (`core_rst`) clears the whole core. A partial reset (`partial_rst`) clears only the program counter and the stack pointer. A partial reset is issued when the watchdog expires while the core is asleep, and it lasts only the oscillator start-up time. A full reset from the pin, the low-voltage detector or power-on lasts the power-on delay plus the start-up time. The start-up time is long (`SST_LONG`, default 1024 cycles) unless the configuration both asks for the short time and declares an RC clock source; only then is it `SST_SHORT` (default 2 cycles).

The control is a three-state machine. The states are S_FULL (full reset counting), S_WAKE (partial reset counting) and S_RUN (released). The transitions are as follows:
- T_FULL_EVT: any state goes to S_FULL on a full-reset event.
- T_WAKE_EVT: S_RUN or S_WAKE goes to S_WAKE when the watchdog expires during sleep.
- T_DONE: S_FULL or S_WAKE goes to S_RUN when the shared down-counter reaches zero with no new event.

The power-on input forces S_FULL asynchronously. Release is always synchronous.

Top module: `mcu_reset_sequencer`

## Requirements
- R1: While `por_n` is low, `core_rst` is 1, `partial_rst` is 0 and both flags are 0. After `por_n` rises, `core_rst` stays 1 for exactly PWR_DLY+SST_LONG rising edges, counting the first edge after the rise.
- R2: `ext_rst_n` passes through a two-flop synchroniser. `core_rst` rises on the third rising edge after the pin goes low. Once the pin is high again, `core_rst` stays 1 for PWR_DLY+SST cycles after the last edge at which the synchronised pin was low. Both flags are left unchanged.
- R3: The low-voltage input counts as an event only after it has been sampled high (after synchronisation) on more than LV_MIN consecutive edges. A pulse LV_MIN cycles wide causes no reset. A pulse LV_MIN+1 cycles wide does.
- R4: With `lvd_en` = 0, the low-voltage input never causes a reset, however long it stays high.
- R5: A low-voltage event holds `core_rst` for PWR_DLY+SST cycles after the event edge and leaves both flags unchanged.
- R6: A watchdog expiry with `sleep_mode` = 0 holds `core_rst` for PWR_DLY+SST cycles. It sets `wdt_flag` to 1 and leaves `pwrdn_flag` unchanged.
- R7: A watchdog expiry with `sleep_mode` = 1 while released holds `partial_rst` for SST cycles. `core_rst` stays 0, and both flags are set to 1.
- R8: The start-up time SST is SST_SHORT only when `cfg_short_sst` = 1 and `cfg_rc_clock` = 1. Otherwise it is SST_LONG. The same choice applies to full and partial resets.
- R9: While released, `sleep_stb` sets `pwrdn_flag` to 1 and `wdt_flag` to 0 on the next edge.
- R10: While released, `clr_wdog_stb` clears both flags. If both strobes come together, `sleep_stb` wins.
- R11: Strobes have no effect while any reset is active, or in a cycle in which a reset event is taken.
- R12: A new event during a running interval restarts the counter with the new event's length. The flags follow the most recent event.
- R13: Throughout a power-on sequence, including intervals restarted by later events, both flags stay 0.
- R14: `core_rst` and `partial_rst` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| lvd_raw | input | 1 | Low-voltage detector output, active high, asynchronous to clk |
| lvd_en | input | 1 | Enables the low-voltage reset |
| wdog_expire | input | 1 | Watchdog expiry strobe, synchronous |
| sleep_mode | input | 1 | Core is in sleep |
| sleep_stb | input | 1 | Sleep instruction strobe |
| clr_wdog_stb | input | 1 | Clear-watchdog instruction strobe |
| cfg_short_sst | input | 1 | Requests the short start-up time |
| cfg_rc_clock | input | 1 | Clock source is an RC oscillator |
| core_rst | output | 1 | Full internal reset |
| partial_rst | output | 1 | Program counter and stack pointer reset only |
| wdt_flag | output | 1 | Sticky watchdog-expired flag |
| pwrdn_flag | output | 1 | Sticky power-down flag |

## Verification
The assertions check the following on every cycle:
- the two reset outputs are mutually exclusive;
- a synchronised pin event or a qualified low-voltage event is followed by full reset;
- a watchdog expiry in sleep enters the partial reset with both flags set;
- each strobe changes the flags correctly while released;
- the flags stay frozen during a full reset unless the watchdog expires;
- the power-on hold state is correct.

Only the bench scenarios can show the exact interval lengths and the start-up time selection. The same applies to the boundary between a rejected and an accepted low-voltage pulse, the effect of the low-voltage enable, counter restart by a later event, and the rule that power-on keeps the flags cleared.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
    typedef enum logic [1:0] {
        S_FULL = 2'd0,
        S_RUN  = 2'd1,
        S_WAKE = 2'd2
    } rsq_state_e;
endpackage

// File: rtl/rsq_sync.sv
`timescale 1ns/1ps
module rsq_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rsq_lv_filter.sv
`timescale 1ns/1ps
module rsq_lv_filter #(
    parameter int MIN_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lv_s,
    input  logic en,
    output logic evt
);
    localparam int CW = $clog2(MIN_CYC + 1);
    logic [CW-1:0] run_len;

    // consecutive high samples, saturating at MIN_CYC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         run_len <= '0;
        else if (!(lv_s && en))             run_len <= '0;
        else if (run_len != CW'(MIN_CYC))   run_len <= run_len + CW'(1);
    end

    assign evt = lv_s && en && (run_len == CW'(MIN_CYC));
endmodule

// File: rtl/rsq_timer.sv
`timescale 1ns/1ps
module rsq_timer #(
    parameter int CW      = 11,
    parameter int RST_VAL = 1023
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= CW'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/mcu_reset_sequencer.sv
`timescale 1ns/1ps
module mcu_reset_sequencer
    import rsq_pkg::*;
#(
    parameter int PWR_DLY     = 400000,
    parameter int SST_LONG    = 1024,
    parameter int SST_SHORT   = 2,
    parameter int LV_MIN      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_n,
    input  logic lvd_raw,
    input  logic lvd_en,
    input  logic wdog_expire,
    input  logic sleep_mode,
    input  logic sleep_stb,
    input  logic clr_wdog_stb,
    input  logic cfg_short_sst,
    input  logic cfg_rc_clock,
    output logic core_rst,
    output logic partial_rst,
    output logic wdt_flag,
    output logic pwrdn_flag
);
    localparam int FULL_MAX = PWR_DLY + SST_LONG;
    localparam int CW       = $clog2(FULL_MAX + 1);

    rsq_state_e    state, state_nx;
    logic          pin_s, lv_s, lv_evt, pin_evt;
    logic          wake_evt, wdog_full, full_evt;
    logic          tmr_done, tmr_load, por_active;
    logic [CW-1:0] sst_len, tmr_val;

    rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(por_n), .d(ext_rst_n), .q(pin_s));

    rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lv_sync (
        .clk(clk), .rst_n(por_n), .d(lvd_raw), .q(lv_s));

    generate
        if (LV_MIN == 0) begin : g_lv_direct
            assign lv_evt = lv_s && lvd_en;
        end else begin : g_lv_filter
            rsq_lv_filter #(.MIN_CYC(LV_MIN)) u_lv_filt (
                .clk(clk), .rst_n(por_n), .lv_s(lv_s), .en(lvd_en), .evt(lv_evt));
        end
    endgenerate

    // event decode
    assign pin_evt   = !pin_s;
    assign wake_evt  = wdog_expire && sleep_mode && (state != S_FULL) && !pin_evt && !lv_evt;
    assign wdog_full = wdog_expire && !wake_evt;
    assign full_evt  = pin_evt || lv_evt || wdog_full;

    assign sst_len  = (cfg_short_sst && cfg_rc_clock) ? CW'(SST_SHORT) : CW'(SST_LONG);
    assign tmr_load = full_evt || wake_evt;
    assign tmr_val  = full_evt ? (CW'(PWR_DLY) + sst_len - CW'(1)) : (sst_len - CW'(1));

    rsq_timer #(.CW(CW), .RST_VAL(FULL_MAX - 1)) u_timer (
        .clk(clk), .rst_n(por_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done));

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= S_FULL;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (full_evt)       state_nx = S_FULL;   // T_FULL_EVT
        else if (wake_evt)  state_nx = S_WAKE;   // T_WAKE_EVT
        else begin
            unique case (state)
                S_RUN:          state_nx = S_RUN;
                S_FULL, S_WAKE: if (tmr_done) state_nx = S_RUN;   // T_DONE
                default:        state_nx = S_FULL;
            endcase
        end
    end

    // power-on sequence marker
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                                        por_active <= 1'b1;
        else if (state == S_FULL && !full_evt && tmr_done) por_active <= 1'b0;
    end

    // sticky flags
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wdt_flag   <= 1'b0;
            pwrdn_flag <= 1'b0;
        end else if (por_active) begin
            wdt_flag   <= 1'b0;
            pwrdn_flag <= 1'b0;
        end else if (wake_evt) begin
            wdt_flag   <= 1'b1;
            pwrdn_flag <= 1'b1;
        end else if (wdog_full) begin
            wdt_flag   <= 1'b1;
        end else if (!full_evt && state == S_RUN) begin
            if (sleep_stb) begin
                wdt_flag   <= 1'b0;
                pwrdn_flag <= 1'b1;
            end else if (clr_wdog_stb) begin
                wdt_flag   <= 1'b0;
                pwrdn_flag <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        core_rst    = 1'b0;
        partial_rst = 1'b0;
        unique case (state)
            S_FULL:  core_rst    = 1'b1;
            S_WAKE:  partial_rst = 1'b1;
            S_RUN:   ;
            default: core_rst    = 1'b1;
        endcase
    end
endmodule

// File: rtl/rsq_checker.sv
`timescale 1ns/1ps
module rsq_checker (
    input logic clk,
    input logic por_n,
    input logic core_rst,
    input logic partial_rst,
    input logic wdt_flag,
    input logic pwrdn_flag,
    input logic wdog_expire,
    input logic sleep_mode,
    input logic sleep_stb,
    input logic clr_wdog_stb,
    input logic pin_evt,
    input logic lv_evt
);
    logic run, no_src;
    assign run    = !core_rst && !partial_rst;
    assign no_src = !pin_evt && !lv_evt && !wdog_expire;

    // R1
    por_hold_chk: assert property (@(posedge clk)
        !por_n |-> (core_rst && !partial_rst && !wdt_flag && !pwrdn_flag));

    // R14
    out_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({core_rst, partial_rst}));

    // R2
    pin_enter_chk: assert property (@(posedge clk) disable iff (!por_n)
        pin_evt |=> core_rst);

    // R5
    lv_enter_chk: assert property (@(posedge clk) disable iff (!por_n)
        lv_evt |=> core_rst);

    // R7
    wake_enter_chk: assert property (@(posedge clk) disable iff (!por_n)
        (run && wdog_expire && sleep_mode && !pin_evt && !lv_evt)
        |=> (partial_rst && !core_rst && wdt_flag && pwrdn_flag));

    // R9
    sleep_stb_chk: assert property (@(posedge clk) disable iff (!por_n)
        (run && no_src && sleep_stb) |=> (pwrdn_flag && !wdt_flag));

    // R10
    clr_stb_chk: assert property (@(posedge clk) disable iff (!por_n)
        (run && no_src && !sleep_stb && clr_wdog_stb) |=> (!pwrdn_flag && !wdt_flag));

    // R11
    flag_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst && !wdog_expire) |=> ($stable(wdt_flag) && $stable(pwrdn_flag)));
endmodule

bind mcu_reset_sequencer rsq_checker u_rsq_chk (
    .clk(clk), .por_n(por_n), .core_rst(core_rst), .partial_rst(partial_rst),
    .wdt_flag(wdt_flag), .pwrdn_flag(pwrdn_flag), .wdog_expire(wdog_expire),
    .sleep_mode(sleep_mode), .sleep_stb(sleep_stb), .clr_wdog_stb(clr_wdog_stb),
    .pin_evt(pin_evt), .lv_evt(lv_evt));

// File: tb/mcu_reset_sequencer_test.sv
`timescale 1ns/1ps
module mcu_reset_sequencer_test;
    localparam int PWR_DLY   = 30;
    localparam int SST_LONG  = 40;
    localparam int SST_SHORT = 2;
    localparam int LV_MIN    = 6;

    logic clk = 1'b0;
    logic por_n = 1'b1, ext_rst_n = 1'b1, lvd_raw = 1'b0, lvd_en = 1'b1;
    logic wdog_expire = 1'b0, sleep_mode = 1'b0, sleep_stb = 1'b0, clr_wdog_stb = 1'b0;
    logic cfg_short_sst = 1'b0, cfg_rc_clock = 1'b0;
    logic core_rst, partial_rst, wdt_flag, pwrdn_flag;

    int  n_chk = 0, n_err = 0;
    bit  m_to = 1'b0, m_pdf = 1'b0;
    int  cnt;

    mcu_reset_sequencer #(.PWR_DLY(PWR_DLY), .SST_LONG(SST_LONG), .SST_SHORT(SST_SHORT),
                          .LV_MIN(LV_MIN), .SYNC_STAGES(2)) uut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .lvd_raw(lvd_raw), .lvd_en(lvd_en),
        .wdog_expire(wdog_expire), .sleep_mode(sleep_mode), .sleep_stb(sleep_stb),
        .clr_wdog_stb(clr_wdog_stb), .cfg_short_sst(cfg_short_sst), .cfg_rc_clock(cfg_rc_clock),
        .core_rst(core_rst), .partial_rst(partial_rst), .wdt_flag(wdt_flag), .pwrdn_flag(pwrdn_flag));

    always #2.5 clk = ~clk;

    function automatic int sst(input bit s, input bit r);
        return (s && r) ? SST_SHORT : SST_LONG;
    endfunction

    function automatic int full_len(input bit s, input bit r);
        return PWR_DLY + sst(s, r);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag);
        chk({tag, " wdt_flag"}, int'(wdt_flag), int'(m_to));
        chk({tag, " pwrdn_flag"}, int'(pwrdn_flag), int'(m_pdf));
    endtask

    // counts negedge samples with the chosen output high, starting now
    task automatic measure(input bit wake, output int n);
        n = 0;
        while (((wake ? partial_rst : core_rst) === 1'b1) && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_wdog();
        @(negedge clk) wdog_expire = 1'b1;
        @(negedge clk) wdog_expire = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk) sleep_stb = 1'b1;
        @(negedge clk) sleep_stb = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr_wdog_stb = 1'b1;
        @(negedge clk) clr_wdog_stb = 1'b0;
    endtask

    // holds pin low until full reset is seen, releases, steps one cycle
    task automatic pin_hit();
        int guard;
        guard = 0;
        @(negedge clk) ext_rst_n = 1'b0;
        while (!core_rst && guard < 20) begin
            guard++;
            @(negedge clk);
        end
        ext_rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(150000 * 5);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005_eed1));
        #1 por_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 hold state
        chk("R1 core_rst in por", int'(core_rst), 1);
        chk("R1 partial_rst in por", int'(partial_rst), 0);
        chk_flags("R1 por");
        por_n = 1'b1;
        measure(1'b0, cnt);
        chk("R1 por length", cnt, PWR_DLY + SST_LONG);

        // R9 sleep strobe
        pulse_sleep(); m_to = 0; m_pdf = 1;
        chk_flags("R9");
        // R10 clear strobe and priority
        pulse_clr(); m_to = 0; m_pdf = 0;
        chk_flags("R10 clear");
        @(negedge clk) begin sleep_stb = 1'b1; clr_wdog_stb = 1'b1; end
        @(negedge clk) begin sleep_stb = 1'b0; clr_wdog_stb = 1'b0; end
        m_to = 0; m_pdf = 1;
        chk_flags("R10 priority");

        // R6 watchdog in normal mode
        pulse_wdog();
        measure(1'b0, cnt);
        m_to = 1;
        chk("R6 length", cnt, full_len(0, 0));
        chk_flags("R6");

        // R2 latency, length with short start-up (R8)
        cfg_short_sst = 1'b1; cfg_rc_clock = 1'b1;
        @(negedge clk) ext_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) chk("R2 not yet after two edges", int'(core_rst), 0);
        @(negedge clk) chk("R2 asserted on third edge", int'(core_rst), 1);
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        @(negedge clk);
        measure(1'b0, cnt);
        chk("R2 R8 pin length short sst", cnt, full_len(1, 1) + 1);
        chk_flags("R2");

        // R3 dip of LV_MIN cycles ignored
        @(negedge clk) lvd_raw = 1'b1;
        repeat (LV_MIN) @(negedge clk);
        lvd_raw = 1'b0;
        cnt = 0;
        repeat (12) begin @(negedge clk); if (core_rst) cnt++; end
        chk("R3 short dip ignored", cnt, 0);

        // R3 R5 R8 pulse of LV_MIN+1 cycles, rc=0 forces long
        cfg_rc_clock = 1'b0;
        @(negedge clk) lvd_raw = 1'b1;
        repeat (LV_MIN + 1) @(negedge clk);
        lvd_raw = 1'b0;
        @(negedge clk) chk("R3 not before qualify", int'(core_rst), 0);
        @(negedge clk) chk("R3 qualified pulse", int'(core_rst), 1);
        measure(1'b0, cnt);
        chk("R5 R8 lv length long sst", cnt, full_len(1, 0));
        chk_flags("R5");

        // R4 disabled
        lvd_en = 1'b0;
        @(negedge clk) lvd_raw = 1'b1;
        cnt = 0;
        repeat (25) begin @(negedge clk); if (core_rst) cnt++; end
        lvd_raw = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 disabled lv", cnt, 0);
        lvd_en = 1'b1;

        // R7 wake reset, short and long (R8)
        pulse_sleep(); m_to = 0; m_pdf = 1;
        sleep_mode = 1'b1; cfg_short_sst = 1'b1; cfg_rc_clock = 1'b1;
        pulse_wdog();
        chk("R7 core stays low", int'(core_rst), 0);
        measure(1'b1, cnt);
        m_to = 1; m_pdf = 1;
        chk("R7 R8 wake short", cnt, SST_SHORT);
        chk_flags("R7");
        cfg_short_sst = 1'b0;
        pulse_wdog();
        measure(1'b1, cnt);
        chk("R7 R8 wake long", cnt, SST_LONG);
        sleep_mode = 1'b0;

        // R11 strobe during reset and strobe with event
        pulse_wdog();
        repeat (3) @(negedge clk);
        pulse_clr();
        measure(1'b0, cnt);
        chk_flags("R11 during reset");
        @(negedge clk) begin wdog_expire = 1'b1; clr_wdog_stb = 1'b1; end
        @(negedge clk) begin wdog_expire = 1'b0; clr_wdog_stb = 1'b0; end
        measure(1'b0, cnt);
        chk_flags("R11 same cycle");

        // R12 restart, flags follow latest event
        pulse_clr(); m_to = 0; m_pdf = 0;
        pin_hit();
        repeat (10) @(negedge clk);
        pulse_wdog();
        measure(1'b0, cnt);
        m_to = 1;
        chk("R12 restart length", cnt, full_len(0, 0));
        chk_flags("R12");

        // R13 power-on wins over later watchdog
        @(negedge clk) por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (5) @(negedge clk);
        pulse_wdog();
        measure(1'b0, cnt);
        m_to = 0; m_pdf = 0;
        chk("R13 restart length", cnt, full_len(0, 0));
        chk_flags("R13");

        // random mix
        for (int i = 0; i < 40; i++) begin
            int  kind;
            bit  s, r;
            s = 1'($urandom % 2); r = 1'($urandom % 2);
            kind = int'($urandom % 5);
            @(negedge clk) begin cfg_short_sst = s; cfg_rc_clock = r; end
            case (kind)
                0: begin pulse_sleep(); m_to = 0; m_pdf = 1; chk_flags("R9 random"); end
                1: begin pulse_clr();   m_to = 0; m_pdf = 0; chk_flags("R10 random"); end
                2: begin
                    pulse_wdog(); measure(1'b0, cnt); m_to = 1;
                    chk("R6 R8 random length", cnt, full_len(s, r));
                    chk_flags("R6 random");
                end
                3: begin
                    sleep_mode = 1'b1;
                    pulse_wdog();
                    chk("R14 random excl", int'(core_rst & partial_rst), 0);
                    measure(1'b1, cnt); m_to = 1; m_pdf = 1;
                    sleep_mode = 1'b0;
                    chk("R7 R8 random length", cnt, sst(s, r));
                    chk_flags("R7 random");
                end
                default: begin
                    pin_hit(); measure(1'b0, cnt);
                    chk("R2 R8 random length", cnt, full_len(s, r) + 1);
                    chk_flags("R2 random");
                end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule